// File: doc/BRIEF.md
# End-of-Write Status Read Logic

This block forms the byte returned on the read side of a byte-wide nonvolatile memory. While no programming period is running it passes the array's read byte straight through. While the write engine reports busy, it replaces the byte with status. Bit 7 is a polling bit: it reads as the complement of the last byte written when the last-written address is read. Bit 6 is a toggle bit: it flips on every new read. The low six bits come from the latched last-written byte.

The block also produces the enable for the external tri-state driver. The output byte is held at zero whenever that enable is low. Both outputs are registered, so they follow the strobe and data inputs by one clock. A new read is counted when the combined read condition (chip select low, output enable low, write enable high) starts. That condition can start by dropping either select line.

Top module: `eow_status_read`

## Requirements
- R1: `rd_drive` is 1 in the cycle after a clock edge that sampled `cs_n`=0, `oe_n`=0 and `we_n`=1, and is 0 after any other combination.
- R2: Whenever `rd_drive` is 0, `rd_data` is all zeros.
- R3: With `busy`=0 and a read active, `rd_data` equals the `arr_data` sampled at the previous edge.
- R4: With `busy`=1 and `addr` equal to `last_addr`, bit 7 of `rd_data` is the inverse of bit 7 of `last_data`.
- R5: With `busy`=1 and `addr` different from `last_addr`, bit 7 of `rd_data` equals bit 7 of `last_data`.
- R6: With `busy`=1, bit 6 of `rd_data` is an internal toggle state. That state inverts at the edge where a read starts, meaning the read condition is true now and was false at the previous edge. A read that stays active, even while `addr` changes, does not invert it again.
- R7: Starting a read by lowering `cs_n` with `oe_n` held low, or by lowering `oe_n` with `cs_n` held low, both count as a new read for R6.
- R8: With `busy`=1, bits 5 to 0 of `rd_data` equal bits 5 to 0 of `last_data`.
- R9: With `busy`=0 the toggle state does not change, so a read that starts in the same cycle that `busy` falls returns true array data on all eight bits.
- R10: After reset `rd_drive` and `rd_data` are 0 and the toggle state is 0, so the first busy read after reset shows bit 6 = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; a read needs it high |
| addr | input | ADDR_W | Current read address |
| arr_data | input | DATA_W | Byte read from the storage array |
| busy | input | 1 | Programming period in progress |
| last_data | input | DATA_W | Last byte written |
| last_addr | input | ADDR_W | Address of the last byte written |
| rd_data | output | DATA_W | Registered read byte |
| rd_drive | output | 1 | Registered tri-state enable for the data bus |

## Verification
A read can start in the same clock edge at which `busy` changes. That edge decides whether the toggle advances and whether the byte is status or array data. The bench drives the start of a read together with the fall of `busy`, and again together with its rise. It expects true array data with an unchanged toggle in the first case, and a status byte with an advanced toggle in the second. Random runs also flip `busy` and the select lines independently, so that these coincidences recur. Every cycle is compared against a reference model kept in the bench.

// File: rtl/eow_status_pkg.sv
package eow_status_pkg;

  // Combined read condition: both selects low, write strobe high.
  function automatic logic read_cond(input logic cs_n, input logic oe_n,
                                     input logic we_n);
    return (!cs_n) && (!oe_n) && we_n;
  endfunction

endpackage

// File: rtl/eow_read_detect.sv
module eow_read_detect
  import eow_status_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic oe_n,
  input  logic we_n,
  output logic rd_act,
  output logic rd_start
);

  logic rd_q;

  assign rd_act   = read_cond(cs_n, oe_n, we_n);
  assign rd_start = rd_act && !rd_q;

  always_ff @(posedge clk) begin
    if (rst) rd_q <= 1'b0;
    else     rd_q <= rd_act;
  end

  // R6: a held read never yields two starts in a row
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    rd_start |=> !rd_start);

endmodule

// File: rtl/eow_toggle_unit.sv
module eow_toggle_unit (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic rd_start,
  output logic tog_next,
  output logic tog_q
);

  assign tog_next = (busy && rd_start) ? !tog_q : tog_q;

  always_ff @(posedge clk) begin
    if (rst) tog_q <= 1'b0;
    else     tog_q <= tog_next;
  end

  // R6
  tog_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_start) |=> (tog_q != $past(tog_q)));

  // R9
  tog_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(tog_q));

endmodule

// File: rtl/eow_status_mux.sv
module eow_status_mux #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 13
) (
  input  logic              rd_act,
  input  logic              busy,
  input  logic              tog,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic [DATA_W-1:0] arr_data,
  input  logic [DATA_W-1:0] last_data,
  output logic [DATA_W-1:0] byte_next
);

  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  logic addr_hit;
  assign addr_hit = (addr == last_addr);

  always_comb begin
    if (!rd_act) begin
      byte_next = '0;
    end else if (!busy) begin
      byte_next = arr_data;
    end else begin
      byte_next           = last_data;
      byte_next[POLL_BIT] = addr_hit ? !last_data[POLL_BIT] : last_data[POLL_BIT];
      byte_next[TOG_BIT]  = tog;
    end
  end

endmodule

// File: rtl/eow_status_read.sv
module eow_status_read #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] arr_data,
  input  logic              busy,
  input  logic [DATA_W-1:0] last_data,
  input  logic [ADDR_W-1:0] last_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive
);

  localparam int POLL_BIT = DATA_W - 1;

  logic              rd_act;
  logic              rd_start;
  logic              tog_next;
  logic              tog_q;
  logic [DATA_W-1:0] byte_next;

  eow_read_detect u_detect (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .rd_act   (rd_act),
    .rd_start (rd_start)
  );

  eow_toggle_unit u_toggle (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .rd_start (rd_start),
    .tog_next (tog_next),
    .tog_q    (tog_q)
  );

  eow_status_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mux (
    .rd_act    (rd_act),
    .busy      (busy),
    .tog       (tog_next),
    .addr      (addr),
    .last_addr (last_addr),
    .arr_data  (arr_data),
    .last_data (last_data),
    .byte_next (byte_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_drive <= 1'b0;
    end else begin
      rd_data  <= byte_next;
      rd_drive <= rd_act;
    end
  end

  // R1
  drive_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rd_drive |-> $past(!cs_n && !oe_n && we_n));

  // R1
  drive_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !oe_n && we_n) |=> rd_drive);

  // R2
  quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_drive |-> (rd_data == '0));

  // R4
  poll_invert_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !oe_n && we_n && busy && addr == last_addr)
      |=> (rd_data[POLL_BIT] == !$past(last_data[POLL_BIT])));

endmodule

// File: tb/eow_status_read_bench.sv
module eow_status_read_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int AW = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0, last_addr = '0;
  logic [DW-1:0] arr_data = '0, last_data = '0;
  logic          busy = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_drive;

  int  total = 0;
  int  bad = 0;
  bit  done = 0;
  bit  m_prev = 0;
  bit  m_tog = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eow_status_read #(.DATA_W(DW), .ADDR_W(AW)) u_eow_status_read (
    .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .arr_data(arr_data), .busy(busy),
    .last_data(last_data), .last_addr(last_addr),
    .rd_data(rd_data), .rd_drive(rd_drive));

  function automatic logic [DW-1:0] exp_byte(bit rd, bit bz, bit tg,
      logic [AW-1:0] a, logic [AW-1:0] la, logic [DW-1:0] ad, logic [DW-1:0] ld);
    logic [DW-1:0] v;
    if (!rd) return '0;
    if (!bz) return ad;
    v = ld;
    v[7] = (a == la) ? ~ld[7] : ld[7];
    v[6] = tg;
    return v;
  endfunction

  task automatic check(string tag, logic [DW-1:0] got_d, logic got_e,
                       logic [DW-1:0] exp_d, logic exp_e);
    total++;
    if (got_d !== exp_d || got_e !== exp_e) begin
      bad++;
      $display("FAIL %s: data=%02h drive=%0b expected data=%02h drive=%0b",
               tag, got_d, got_e, exp_d, exp_e);
    end
  endtask

  // Drive one cycle of inputs at a falling edge, check at the next falling edge.
  task automatic step(string tag, bit c, bit o, bit w, logic [AW-1:0] a,
                      logic [DW-1:0] ad, bit bz, logic [DW-1:0] ld, logic [AW-1:0] la);
    bit rd;
    logic [DW-1:0] e;
    @(negedge clk);
    cs_n = c; oe_n = o; we_n = w; addr = a; arr_data = ad;
    busy = bz; last_data = ld; last_addr = la;
    rd = !c && !o && w;
    if (bz && rd && !m_prev) m_tog = !m_tog;
    m_prev = rd;
    e = exp_byte(rd, bz, m_tog, a, la, ad, ld);
    @(negedge clk);
    check(tag, rd_data, rd_drive, e, rd);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: data=%02h drive=%0b expected data=xx drive=x", rd_data, rd_drive);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [DW-1:0] gd;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    check("R10", rd_data, rd_drive, 8'h00, 1'b0);

    // R10: first busy read after reset shows toggle = 1
    step("R10", 0, 0, 1, 13'h0155, 8'h3C, 1, 8'h5A, 13'h0155);
    // R4: bit 7 inverted at last address, R8 low bits from last_data
    step("R4", 0, 0, 1, 13'h0155, 8'h3C, 1, 8'h5A, 13'h0155);
    step("R2", 1, 0, 1, 13'h0155, 8'h3C, 1, 8'h5A, 13'h0155);
    // R6: new read flips bit 6
    step("R6", 0, 0, 1, 13'h0155, 8'h3C, 1, 8'hA5, 13'h0155);
    // R6: address change during held read does not flip
    step("R6", 0, 0, 1, 13'h0AAA, 8'h3C, 1, 8'hA5, 13'h0155);
    // R5: other address returns true bit 7
    step("R5", 0, 0, 1, 13'h0AAA, 8'h3C, 1, 8'hA5, 13'h0155);
    // R7: read start by oe_n with cs_n low
    step("R7", 0, 1, 1, 13'h0155, 8'h00, 1, 8'hA5, 13'h0155);
    step("R7", 0, 0, 1, 13'h0155, 8'h00, 1, 8'hA5, 13'h0155);
    // R7: read start by cs_n with oe_n low
    step("R7", 1, 0, 1, 13'h0155, 8'h00, 1, 8'hA5, 13'h0155);
    step("R7", 0, 0, 1, 13'h0155, 8'h00, 1, 8'hA5, 13'h0155);
    // R1: we_n low blocks drive
    step("R1", 0, 0, 0, 13'h0155, 8'hFF, 1, 8'hA5, 13'h0155);
    // R9: read start coinciding with busy fall gives true data
    step("R9", 0, 0, 1, 13'h0155, 8'hC3, 0, 8'hA5, 13'h0155);
    step("R3", 1, 1, 1, 13'h0155, 8'hC3, 0, 8'hA5, 13'h0155);
    // R9: idle reads leave the toggle alone
    step("R9", 0, 0, 1, 13'h0011, 8'h81, 0, 8'hA5, 13'h0155);
    step("R2", 1, 1, 1, 13'h0011, 8'h81, 0, 8'hA5, 13'h0155);
    step("R3", 0, 0, 1, 13'h0012, 8'h7E, 0, 8'hA5, 13'h0155);
    step("R2", 0, 1, 1, 13'h0012, 8'h7E, 0, 8'hA5, 13'h0155);
    // R6: read start together with busy rise advances the toggle
    step("R6", 0, 0, 1, 13'h0155, 8'h7E, 1, 8'h0F, 13'h0155);
    // R8: low bits follow last_data
    step("R8", 0, 0, 1, 13'h0155, 8'h7E, 1, 8'h33, 13'h0155);

    // Random phase
    for (int i = 0; i < 2000; i++) begin
      bit c, o, w, bz;
      logic [AW-1:0] a, la;
      logic [DW-1:0] ad, ld;
      string tg;
      c  = ($urandom % 4) == 0;
      o  = ($urandom % 3) == 0;
      w  = ($urandom % 8) != 0;
      bz = ($urandom % 3) != 0;
      la = 13'h0100 + 13'($urandom % 4);
      a  = 13'h0100 + 13'($urandom % 4);
      ad = 8'($urandom);
      ld = 8'($urandom);
      if (!(!c && !o && w)) tg = "R2";
      else if (!bz) tg = "R3";
      else tg = "R6";
      step(tg, c, o, w, a, ad, bz, ld, la);
    end

    gd = rd_data;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule